// File: doc/BRIEF.md
# Opcode-Selected Arithmetic and Logic Unit

This block is the combinational arithmetic and logic core of a small register machine. One operand, `op_a`, comes from an operand holding register that the sequencer fills with the source register in an earlier step. The other, `op_b`, comes from the shared source bus and carries the destination register. A 4-bit opcode, taken straight from the instruction word, picks the operation. The block returns a result of the same width and a flag that is high when that result is zero.

The block holds no state. The result and the flag follow the inputs within the same clock cycle. Whatever captures the result and the flag, such as the destination register or the external flag register, samples them at the next edge. Add, subtract and multiply all wrap at the operand width, and the block has no carry or overflow output. Opcodes that do not name an ALU operation give a zero result, so the flag reads high for them.

Top module: `alu16_core`

## Requirements
- R1: Opcode 4'b0001 gives op_a + op_b, truncated to WIDTH bits (wraps modulo 2^WIDTH).
- R2: Opcode 4'b0010 gives op_a - op_b, where op_a is the source and op_b the destination, truncated to WIDTH bits.
- R3: Opcode 4'b1001 gives the low WIDTH bits of the full product op_a * op_b.
- R4: Opcode 4'b0011 gives the bitwise AND of op_a and op_b.
- R5: Opcode 4'b1010 gives the bitwise OR of op_a and op_b.
- R6: Opcode 4'b1011 gives the bitwise XOR of op_a and op_b.
- R7: Opcode 4'b1100 gives the bitwise XNOR of op_a and op_b.
- R8: Opcode 4'b0100 gives the bitwise inverse of op_a. For this opcode op_b has no effect on the result.
- R9: Opcode 4'b0000 and every opcode not listed in R1 to R8 (0101, 0110, 0111, 1000, 1101, 1110, 1111) give a result of all zeros, whatever the operands.
- R10: `zero` is 1 exactly when every bit of `result` is 0, for every opcode.
- R11: The block is purely combinational. `result` and `zero` reflect new inputs in the same cycle, with no register stage between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Source operand, taken from the operand holding register |
| op_b | input | WIDTH | Destination operand, taken from the shared source bus |
| opcode | input | 4 | Operation select, taken directly from the instruction |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds two instances. One has the default WIDTH of 16, and the other has WIDTH of 4.

The 16-bit instance gets directed corner cases: carry out of the top bit, borrow below zero, products whose low half is zero, and an inversion of all ones. It then gets a pseudo-random sweep over every opcode.

The 4-bit instance makes an exhaustive sweep possible: all 4096 combinations of opcode and both operands. Every wrap, every unused opcode and every path by which the zero flag can be set is therefore checked on the same generate structure that the wide build uses.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_NONE = 4'b0000,
    OPC_ADD  = 4'b0001,
    OPC_SUB  = 4'b0010,
    OPC_AND  = 4'b0011,
    OPC_INV  = 4'b0100,
    OPC_MUL  = 4'b1001,
    OPC_OR   = 4'b1010,
    OPC_XOR  = 4'b1011,
    OPC_XNOR = 4'b1100
  } alu_opc_e;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] dst_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] diff_o,
  output logic [WIDTH-1:0] prod_o
);

  // All three results wrap at WIDTH bits; no carry leaves this module.
  assign sum_o  = src_i + dst_i;
  assign diff_o = src_i - dst_i;
  assign prod_o = src_i * dst_i;

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] dst_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] xnor_o,
  output logic [WIDTH-1:0] inv_o
);

  // Per-bit cells, one slice per bit position.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i]  = src_i[i] & dst_i[i];
    assign or_o[i]   = src_i[i] | dst_i[i];
    assign xor_o[i]  = src_i[i] ^ dst_i[i];
    assign xnor_o[i] = ~(src_i[i] ^ dst_i[i]);
    assign inv_o[i]  = ~src_i[i];
  end

endmodule

// File: rtl/alu16_zero_detect.sv
module alu16_zero_detect #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] value_i,
  output logic             zero_o
);

  localparam int NGRP   = (WIDTH + GROUP - 1) / GROUP;
  localparam int PADDED = NGRP * GROUP;

  logic [PADDED-1:0] padded;
  logic [NGRP-1:0]   grp_any;

  // Pad with zeros so that every group is full width.
  assign padded = {{(PADDED-WIDTH){1'b0}}, value_i};

  // First level: OR within each group. Second level: NOR across groups.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GROUP +: GROUP];
  end

  assign zero_o = ~|grp_any;

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       opcode,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  logic [WIDTH-1:0] sum_w, diff_w, prod_w;
  logic [WIDTH-1:0] and_w, or_w, xor_w, xnor_w, inv_w;

  alu16_arith #(.WIDTH(WIDTH)) u_arith (
    .src_i  (op_a),
    .dst_i  (op_b),
    .sum_o  (sum_w),
    .diff_o (diff_w),
    .prod_o (prod_w)
  );

  alu16_logic #(.WIDTH(WIDTH)) u_logic (
    .src_i  (op_a),
    .dst_i  (op_b),
    .and_o  (and_w),
    .or_o   (or_w),
    .xor_o  (xor_w),
    .xnor_o (xnor_w),
    .inv_o  (inv_w)
  );

  // Result select, decoded straight from the instruction opcode.
  always_comb begin
    unique case (alu_opc_e'(opcode))
      OPC_ADD:  result = sum_w;
      OPC_SUB:  result = diff_w;
      OPC_MUL:  result = prod_w;
      OPC_AND:  result = and_w;
      OPC_OR:   result = or_w;
      OPC_XOR:  result = xor_w;
      OPC_XNOR: result = xnor_w;
      OPC_INV:  result = inv_w;
      default:  result = '0;
    endcase
  end

  alu16_zero_detect #(.WIDTH(WIDTH), .GROUP(4)) u_zero (
    .value_i (result),
    .zero_o  (zero)
  );

  // Each check below uses the inverse of its operation, so none repeats the datapath.
  always_comb begin
    // R1
    add_wrap_chk: assert (!(opcode == 4'b0001) || ((result - op_b) == op_a));
    // R2
    sub_order_chk: assert (!(opcode == 4'b0010) || ((result + op_b) == op_a));
    // R3
    mul_lsb_chk: assert (!(opcode == 4'b1001) || (result[0] == (op_a[0] & op_b[0])));
    // R6
    xor_inverse_chk: assert (!(opcode == 4'b1011) || ((result ^ op_b) == op_a));
    // R7
    xnor_inverse_chk: assert (!(opcode == 4'b1100) || ((~result ^ op_b) == op_a));
    // R8
    inv_only_a_chk: assert (!(opcode == 4'b0100) || ((result ^ op_a) == {WIDTH{1'b1}}));
    // R9
    unused_opc_chk: assert (!(opcode inside {4'b0000, 4'b0101, 4'b0110, 4'b0111,
                                             4'b1000, 4'b1101, 4'b1110, 4'b1111})
                            || ($countones(result) == 0));
    // R10
    zero_flag_chk: assert (zero == ($countones(result) == 0));
  end

endmodule

// File: tb/alu16_core_bench.sv
module alu16_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WW = 16;
  localparam int NW = 4;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [WW-1:0] a_w, b_w, r_w;
  logic [3:0]    op_w;
  logic          z_w;
  logic [NW-1:0] a_n, b_n, r_n;
  logic [3:0]    op_n;
  logic          z_n;

  alu16_core #(.WIDTH(WW)) u_alu16_core (
    .op_a(a_w), .op_b(b_w), .opcode(op_w), .result(r_w), .zero(z_w)
  );

  alu16_core #(.WIDTH(NW)) u_alu16_core_narrow (
    .op_a(a_n), .op_b(b_n), .opcode(op_n), .result(r_n), .zero(z_n)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] seed = 32'h1234_abcd;

  // Behavioural reference: integer arithmetic, then mask to the width.
  function automatic longint unsigned model(longint unsigned a, longint unsigned b,
                                            int op, int w);
    longint unsigned m = (64'd1 << w) - 1;
    longint unsigned v;
    case (op)
      1:  v = a + b;
      2:  v = a + ((~b + 1) & m);
      9:  v = a * b;
      3:  v = a & b;
      10: v = a | b;
      11: v = a ^ b;
      12: v = ~(a ^ b);
      4:  v = ~a;
      default: v = 0;
    endcase
    return v & m;
  endfunction

  function automatic string req_of(int op);
    case (op)
      1: return "R1";  2: return "R2";  9: return "R3";  3: return "R4";
      10: return "R5"; 11: return "R6"; 12: return "R7"; 4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic judge(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive after a falling edge and compare after the next rising edge.
  task automatic vec_wide(logic [WW-1:0] a, logic [WW-1:0] b, logic [3:0] op);
    longint unsigned e;
    @(negedge clk);
    a_w = a; b_w = b; op_w = op;
    @(posedge clk); #1;
    e = model(a, b, int'(op), WW);
    judge(req_of(int'(op)), r_w, e);
    judge("R10", z_w, (e == 0) ? 1 : 0);
  endtask

  task automatic vec_narrow(logic [NW-1:0] a, logic [NW-1:0] b, logic [3:0] op);
    longint unsigned e;
    @(negedge clk);
    a_n = a; b_n = b; op_n = op;
    @(posedge clk); #1;
    e = model(a, b, int'(op), NW);
    judge(req_of(int'(op)), r_n, e);
    judge("R10", z_n, (e == 0) ? 1 : 0);
  endtask

  function automatic logic [31:0] step(logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    a_w = '0; b_w = '0; op_w = '0;
    a_n = '0; b_n = '0; op_n = '0;
    repeat (3) @(posedge clk);
    #1;
    // Reset state: all-zero inputs give zero result and a raised flag (R9, R10).
    judge("R9", r_w, 0);
    judge("R10", z_w, 1);
    rst_n = 1'b1;

    // R11: the result follows the inputs with no clock edge in between.
    @(negedge clk);
    a_w = 16'h0003; b_w = 16'h0004; op_w = 4'b0001;
    #1;
    judge("R11", r_w, 16'h0007);

    // Directed corners on the 16-bit build.
    vec_wide(16'hFFFF, 16'h0001, 4'b0001); // R1 wrap to zero, flag high
    vec_wide(16'h1234, 16'h4321, 4'b0001); // R1
    vec_wide(16'h0000, 16'h0001, 4'b0010); // R2 borrow wrap
    vec_wide(16'h0005, 16'h0003, 4'b0010); // R2 source minus destination
    vec_wide(16'h0003, 16'h0005, 4'b0010); // R2 order check
    vec_wide(16'h7777, 16'h7777, 4'b0010); // R2 zero result
    vec_wide(16'h0100, 16'h0100, 4'b1001); // R3 low half zero
    vec_wide(16'hFFFF, 16'hFFFF, 4'b1001); // R3 gives 1
    vec_wide(16'h00FF, 16'h0F0F, 4'b0011); // R4
    vec_wide(16'hF000, 16'h000F, 4'b1010); // R5
    vec_wide(16'hAAAA, 16'hAAAA, 4'b1011); // R6 zero
    vec_wide(16'hAAAA, 16'h5555, 4'b1100); // R7 zero
    vec_wide(16'hFFFF, 16'h0000, 4'b0100); // R8 zero
    vec_wide(16'h1234, 16'h0000, 4'b0100); // R8 with b = 0
    vec_wide(16'h1234, 16'hBEEF, 4'b0100); // R8 b has no effect
    for (int op = 0; op < 16; op++) begin
      vec_wide(16'hFFFF, 16'hFFFF, 4'(op)); // R9 unused opcodes, all operands set
    end

    // Pseudo-random sweep on the wide build.
    for (int i = 0; i < 1500; i++) begin
      seed = step(seed);
      vec_wide(seed[15:0], seed[31:16], 4'(i % 16));
    end

    // Exhaustive sweep on the 4-bit build (R1..R10).
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          vec_narrow(4'(a), 4'(b), 4'(op));
        end
      end
    end

    finish_run();
  end

endmodule